// File: doc/BRIEF.md
# Operand Transition Class Histogram

This block watches a stream of two-operand samples and gathers statistics on how each operand changes from one accepted sample to the next. For each operand it compares the new word with the previous accepted word. It counts the bit positions that toggled (the toggle count) and the positions that stayed at one (the held-one count). The positions that stayed at zero make up the rest of the word. Both counts are turned into fractions of the operand width and rounded to quarters. Each operand then falls into one of fifteen classes, and a joint counter for the (A class, B class) combination is incremented.

The result is a 225-entry occurrence histogram plus a total of the pairs seen. A power estimator can weight this histogram afterwards. The counters are read through a one-cycle registered read port. A synchronous clear restarts collection.

Top module: `tch_top`

## Requirements
- R1: The toggle count of an operand is the number of bit positions that differ between the current and the previous accepted word.
- R2: The held-one count is the number of bit positions that are 1 in both words. The held-zero count is the width minus the other two counts.
- R3: Each count is mapped to a level 0..4: the fraction count/width rounded to the nearest quarter, with exact ties rounded up. If the two levels sum to more than 4, the held-one level becomes 4 minus the toggle level.
- R4: The operand class is 5*t - t*(t-1)/2 + s, where t is the toggle level and s the held-one level. This numbers the 15 valid (t, s) pairs in row-major order, 0 to 14.
- R5: Each accepted pair increments exactly one counter, the one at joint index classA*15 + classB (0 to 224).
- R6: The first accepted sample after reset or clear only becomes the previous word. It changes no counter.
- R7: The pair total equals the number of accepted samples minus one, counted since the last reset or clear.
- R8: Histogram counters and the pair total saturate at their all-ones value.
- R9: A clear zeroes all counters and the pair total, and it forgets the previous word. A sample presented in the same cycle as a clear is discarded.
- R10: rd_cnt shows the counter selected by rd_idx at the previous clock edge. Indices 225 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all statistics |
| in_valid | input | 1 | Sample on in_a/in_b is accepted this cycle |
| in_a | input | WA | Operand A sample |
| in_b | input | WB | Operand B sample |
| rd_idx | input | 8 | Joint class index to read |
| rd_cnt | output | CNT_W | Registered counter value |
| pair_total | output | PAIR_W | Saturating count of accepted pairs |

## Verification
Directed pairs are used to isolate single effects. These are a word followed by its complement, which gives a pure toggle class. They also include a repeated word, which gives a pure held-one class, and an eighth-width toggle, which probes tie rounding and clipping. Each directed pair must land on a precomputed joint index. A long repeat of one sample drives a single counter and the pair total into saturation. A random stream with gaps, on operands of unequal widths, is checked across all 225 entries against a bench model. That comparison shows up any mistake in the class ordering or in the A/B weighting. Clears placed together with a valid sample separate the discard rule from the first-sample rule.

// File: rtl/tch_pkg.sv
package tch_pkg;
  localparam int NLEV   = 5;
  localparam int NCLS   = 15;
  localparam int NJOINT = NCLS * NCLS;

  // R3: fraction cnt/width to nearest quarter, ties up
  function automatic logic [2:0] quarter_level(int cnt, int width);
    return 3'((8 * cnt + width) / (2 * width));
  endfunction

  // R3/R4: clip held-one level, then row-major class number
  function automatic logic [3:0] class_of(logic [2:0] t, logic [2:0] s);
    int ti, si;
    ti = int'(t);
    si = int'(s);
    if (ti + si > 4) si = 4 - ti;
    return 4'(5 * ti - (ti * (ti - 1)) / 2 + si);
  endfunction
endpackage

// File: rtl/tch_operand_stats.sv
module tch_operand_stats #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chk_en,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  output logic [3:0]   cls
);
  import tch_pkg::*;
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] tog_cnt, one_cnt;
  logic [2:0]    tog_lvl, one_lvl;

  always_comb begin
    tog_cnt = '0;
    one_cnt = '0;
    for (int i = 0; i < W; i++) begin
      tog_cnt = tog_cnt + CW'(cur[i] ^ prev[i]);
      one_cnt = one_cnt + CW'(cur[i] & prev[i]);
    end
  end

  assign tog_lvl = quarter_level(int'(tog_cnt), W);
  assign one_lvl = quarter_level(int'(one_cnt), W);
  assign cls     = class_of(tog_lvl, one_lvl);

  // R1/R2: toggle and held-one positions are disjoint
  assert_count_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (int'(tog_cnt) + int'(one_cnt) <= W));
  // R4: class within the 15 valid codes
  assert_class_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (cls < 4'd15));
  // R3: levels never exceed one whole
  assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (tog_lvl <= 3'd4 && one_lvl <= 3'd4));
endmodule

// File: rtl/tch_counter_bank.sv
module tch_counter_bank #(
  parameter int NUM   = 225,
  parameter int IW    = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_en,
  input  logic [IW-1:0]    inc_idx,
  input  logic [IW-1:0]    rd_idx,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic hit;
    assign hit = inc_en && (inc_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q[g] <= '0;
      else if (clr)                       cnt_q[g] <= '0;
      else if (hit && cnt_q[g] != CMAX)   cnt_q[g] <= cnt_q[g] + 1'b1;
    end

    // R8: a full counter stays full until cleared
    assert_cnt_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt_q[g] == CMAX) |=> (cnt_q[g] == CMAX));
    // R5: a counter moves by at most one per cycle
    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr) |=> (cnt_q[g] == $past(cnt_q[g]) ||
                  cnt_q[g] == CNT_W'($past(cnt_q[g]) + 1'b1)));
    // R9: clear empties the counter
    assert_cnt_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q[g] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rd_cnt <= '0;
    else if (rd_idx < IW'(NUM))  rd_cnt <= cnt_q[rd_idx];
    else                         rd_cnt <= '0;
  end

  // R10: out-of-range index reads zero one cycle later
  assert_rd_oob_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >= IW'(NUM)) |=> (rd_cnt == '0));
endmodule

// File: rtl/tch_top.sv
module tch_top #(
  parameter int WA     = 8,
  parameter int WB     = 8,
  parameter int CNT_W  = 16,
  parameter int PAIR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [WA-1:0]     in_a,
  input  logic [WB-1:0]     in_b,
  input  logic [7:0]        rd_idx,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [PAIR_W-1:0] pair_total
);
  import tch_pkg::*;
  localparam int JW = 8;
  localparam logic [PAIR_W-1:0] PMAX = '1;

  logic [WA-1:0]     prev_a_q;
  logic [WB-1:0]     prev_b_q;
  logic              have_prev_q;
  logic [PAIR_W-1:0] pair_q;
  logic [3:0]        cls_a, cls_b;
  logic [JW-1:0]     joint_idx;
  logic              accept, pair_evt;

  assign accept   = in_valid && !clr;
  assign pair_evt = accept && have_prev_q;

  tch_operand_stats #(.W(WA)) u_stats_a (
    .clk(clk), .rst_n(rst_n), .chk_en(pair_evt),
    .cur(in_a), .prev(prev_a_q), .cls(cls_a));

  tch_operand_stats #(.W(WB)) u_stats_b (
    .clk(clk), .rst_n(rst_n), .chk_en(pair_evt),
    .cur(in_b), .prev(prev_b_q), .cls(cls_b));

  assign joint_idx = JW'(cls_a) * JW'(NCLS) + JW'(cls_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a_q    <= '0;
      prev_b_q    <= '0;
      have_prev_q <= 1'b0;
      pair_q      <= '0;
    end else if (clr) begin
      have_prev_q <= 1'b0;
      pair_q      <= '0;
    end else if (in_valid) begin
      prev_a_q    <= in_a;
      prev_b_q    <= in_b;
      have_prev_q <= 1'b1;
      if (have_prev_q && pair_q != PMAX) pair_q <= pair_q + 1'b1;
    end
  end

  assign pair_total = pair_q;

  tch_counter_bank #(.NUM(NJOINT), .IW(JW), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .inc_en(pair_evt), .inc_idx(joint_idx),
    .rd_idx(rd_idx), .rd_cnt(rd_cnt));

  // R6: first sample after reset/clear adds no pair
  assert_first_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !have_prev_q) |=> (pair_total == $past(pair_total)));
  // R7: pair total advances by one per accepted pair, else holds
  assert_pair_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !in_valid) |=> $stable(pair_total));
  // R8: saturated pair total stays put
  assert_pair_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && pair_total == PMAX) |=> (pair_total == PMAX));
  // R9: clear restarts collection
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pair_total == '0 && !have_prev_q));
  // R5: joint index inside the histogram
  assert_joint_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_evt |-> (joint_idx < JW'(NJOINT)));
endmodule

// File: tb/tch_top_bench.sv
`timescale 1ns/1ps
module tch_top_bench;
  localparam int WA = 8, WB = 6, CNT_W = 4, PAIR_W = 6;
  localparam int CMAXV = 15, PMAXV = 63;

  logic clk = 0, rst_n = 0, clr = 0, in_valid = 0;
  logic [WA-1:0] in_a = '0;
  logic [WB-1:0] in_b = '0;
  logic [7:0] rd_idx = '0;
  logic [CNT_W-1:0] rd_cnt;
  logic [PAIR_W-1:0] pair_total;

  always #4 clk = ~clk;

  tch_top #(.WA(WA), .WB(WB), .CNT_W(CNT_W), .PAIR_W(PAIR_W)) u_tch_top (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .rd_idx(rd_idx),
    .rd_cnt(rd_cnt), .pair_total(pair_total));

  int checks = 0, errors = 0;
  int exp_hist [225];
  int exp_pairs = 0;
  bit m_have = 0;
  logic [WA-1:0] m_pa;
  logic [WB-1:0] m_pb;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int b_level(int c, int w);
    int best = 0;
    for (int l = 0; l <= 4; l++) begin
      int d = 4 * c - l * w;
      if (d < 0) d = -d;
      if (2 * d <= w) best = l;  // later (larger) wins ties
    end
    return best;
  endfunction

  function automatic int b_class(int t, int s);
    int n = 0;
    if (t + s > 4) s = 4 - t;
    for (int ti = 0; ti <= 4; ti++)
      for (int si = 0; si + ti <= 4; si++) begin
        if (ti == t && si == s) return n;
        n++;
      end
    return -1;
  endfunction

  function automatic int b_opclass(logic [31:0] cur, logic [31:0] prv, int w);
    int h = 0, s = 0;
    for (int i = 0; i < w; i++) begin
      if (cur[i] != prv[i]) h++;
      if (cur[i] && prv[i]) s++;
    end
    return b_class(b_level(h, w), b_level(s, w));
  endfunction

  task automatic model_clear();
    foreach (exp_hist[k]) exp_hist[k] = 0;
    exp_pairs = 0;
    m_have = 0;
  endtask

  task automatic push(logic [WA-1:0] a, logic [WB-1:0] b);
    in_valid = 1; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 0;
    if (m_have) begin
      int j = b_opclass(32'(a), 32'(m_pa), WA) * 15 + b_opclass(32'(b), 32'(m_pb), WB);
      if (exp_hist[j] < CMAXV) exp_hist[j]++;
      if (exp_pairs < PMAXV) exp_pairs++;
    end
    m_have = 1; m_pa = a; m_pb = b;
  endtask

  task automatic do_clear();
    clr = 1;
    @(negedge clk);
    clr = 0;
    model_clear();
  endtask

  task automatic read_at(int k, output int v);
    rd_idx = 8'(k);
    @(negedge clk);
    v = int'(rd_cnt);
  endtask

  task automatic check_all(string tag);
    int v;
    for (int k = 0; k < 225; k++) begin
      read_at(k, v);
      chk(tag, v, exp_hist[k]);
    end
    chk({tag, " R7 pairs"}, int'(pair_total), exp_pairs);
  endtask

  // one directed pair, expected joint index precomputed by hand
  task automatic directed(string tag, logic [WA-1:0] a0, logic [WB-1:0] b0,
                          logic [WA-1:0] a1, logic [WB-1:0] b1, int idx);
    int v;
    do_clear();
    push(a0, b0);
    push(a1, b1);
    read_at(idx, v);
    chk(tag, v, 1);
    chk({tag, " R7 pairs"}, int'(pair_total), 1);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd1234));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    read_at(0, v);
    chk("reset R10 rd_cnt", v, 0);
    chk("reset R7 pair_total", int'(pair_total), 0);

    // R6: lone first sample
    push(8'hA5, 6'h2A);
    chk("R6 first sample pair_total", int'(pair_total), 0);
    check_all("R6 histogram after first sample");

    // R1: full complement -> toggle level 4 both: class 14, joint 224
    directed("R1 complement", 8'h00, 6'h00, 8'hFF, 6'h3F, 224);
    // R2: repeated word, half ones -> (0,2)=2 both: joint 32
    directed("R2 held ones", 8'h0F, 6'h07, 8'h0F, 6'h07, 32);
    // R3: A toggle 1/8 -> level 1 (tie up), held 7/8 -> 4 clipped to 3: class 8
    //     B toggle 3/6 -> 2, held 0: class 9; joint 129
    directed("R3 tie and clip", 8'hFE, 6'h00, 8'hFF, 6'h07, 129);
    // R4: A toggle 4/8 -> (2,0)=9, B held 6/6 -> (0,4)=4; joint 139
    directed("R4 row-major", 8'h00, 6'h3F, 8'hF0, 6'h3F, 139);
    // R5: swap roles: A held-all 8 -> 4, B toggle 6 -> 14; joint 74
    directed("R5 A/B weighting", 8'hFF, 6'h00, 8'hFF, 6'h3F, 74);

    // R8: long repeat saturates one counter and pair total
    do_clear();
    for (int i = 0; i < 70; i++) push(8'h3C, 6'h15);
    check_all("R8 saturation");

    // R9: clear with a valid sample in the same cycle
    clr = 1; in_valid = 1; in_a = 8'h11; in_b = 6'h11;
    @(negedge clk);
    clr = 0; in_valid = 0;
    model_clear();
    chk("R9 pair_total after clear", int'(pair_total), 0);
    push(8'h22, 6'h22);
    chk("R9 R6 sample after clear is first", int'(pair_total), 0);
    push(8'h22, 6'h22);
    chk("R9 second sample after clear", int'(pair_total), 1);

    // random streams with gaps
    for (int r = 0; r < 3; r++) begin
      do_clear();
      for (int i = 0; i < 55; i++) begin
        logic [WA-1:0] a;
        logic [WB-1:0] b;
        a = WA'($urandom);
        b = WB'($urandom);
        if ($urandom % 4 == 0) a = m_pa ^ WA'(1 << ($urandom % WA));
        push(a, b);
        if ($urandom % 3 == 0) @(negedge clk);
      end
      check_all("R5 random stream");
    end

    // R10: out-of-range read and read latency
    read_at(230, v);
    chk("R10 out-of-range read", v, 0);
    read_at(255, v);
    chk("R10 top index read", v, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule